// File: doc/BRIEF.md
# Three-Wire Serial Memory Slave Front End

This block sits behind the pins of a three-wire serial memory port: chip select, serial clock, serial data in and serial data out. It runs on the chip's system clock and oversamples the serial clock to find its rising edges. On each rising edge it shifts in one bit of a frame. A frame is a start bit of 1, then a 2-bit opcode, then an address field of `AW` bits, MSB first. Write-type frames carry a further `DW` data bits. Zeros on the data line before the start bit are skipped.

When the address field is complete, the frame is decoded into one of eleven command kinds. The protect-select pin picks whether the opcode acts on the memory array or on the protect register. Each decoded command is handed to the downstream permission checker and programming sequencer as a one-cycle pulse, together with its kind, address and data.

Array reads and protect-register reads drive serial data out. The output enable models the pad's high-impedance state. An array read first sends one zero dummy bit. It then sends words MSB first, back to back, with the address advancing and wrapping after each word and no further dummy bits. Pulling chip select low clears all frame and read state.

Top module: `uw_mem_slave`

## Requirements
- R1: After reset, `dout_oe` and `cmd_valid` are 0.
- R2: Zeros on `di` before the first 1 are ignored. After that start bit, the next 2 rising `sck` edges shift in the opcode and the next `AW` edges shift in the address, both MSB first.
- R3: With `psel` low at the last address bit, commands are decoded as follows:
  - opcode 10 is a read (kind 1);
  - opcode 01 is a write (kind 2) and takes `DW` data bits;
  - opcode 11 is a clear (kind 3);
  - opcode 00 uses the top two address bits: 11 is write-enable (kind 4), 01 is write-all (kind 5) and takes `DW` data bits, 00 is write-disable (kind 6), and 10 is no command.
- R4: With `psel` high at the last address bit, commands are decoded as follows:
  - opcode 10 is protect read (kind 7);
  - opcode 00 with top address bits 11 is protect-enable (kind 8);
  - opcode 11 with an all-ones address is protect-clear (kind 9), and any other address is no command;
  - opcode 01 is protect-write (kind 10);
  - opcode 00 with an all-zero address is protect-disable (kind 11);
  - any other opcode 00 address is no command.
- R5: On the edge that takes the last address bit of an array read, `dout_oe` rises with `dout`=0. Each following rising edge presents the next bit of word `rd_addr`, MSB first.
- R6: After the last bit of a word, the next edge presents the MSB of the following address's word with no dummy bit. The address wraps from 2^AW-1 to 0.
- R7: A protect read sends the dummy 0 and then the `AW` bits of `prot_addr`, MSB first. On the next edge `dout_oe` falls.
- R8: Chip select low drops `dout_oe` within one clock and discards a partial frame. No command is reported from a discarded frame, and the next frame decodes normally.
- R9: `cmd_valid` is a one-clock pulse in the clock after the completing `sck` edge. For data-carrying kinds that edge is the last data bit, and `cmd_data` holds the data. For all other kinds it is the last address bit. `cmd_addr` holds the address in both cases.
- R10: `dout_oe` stays 0 outside a read or protect-read output phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs | input | 1 | Chip select, active high |
| sck | input | 1 | Serial clock, oversampled |
| di | input | 1 | Serial data in |
| psel | input | 1 | Protect-register select |
| rd_addr | output | AW | Word address being read |
| rd_data | input | DW | Array word at `rd_addr` |
| prot_addr | input | AW | Stored protect address |
| dout | output | 1 | Serial data out |
| dout_oe | output | 1 | Data out drive enable |
| cmd_valid | output | 1 | Decoded-command pulse |
| cmd_kind | output | 4 | Command kind code |
| cmd_addr | output | AW | Command address |
| cmd_data | output | DW | Command data word |

## Verification
Frames are sent for every opcode under both `psel` levels, with some frames preceded by leading zeros. Reserved address patterns are included to separate the decode of real commands from the no-command cases. Reads are streamed across a word boundary, both in the middle of the array and at the top address, which shows the missing second dummy bit and the address wrap. Protect reads are clocked one edge past their last bit to show the output release. Chip select is pulled low both in the middle of a frame and in the middle of a stream, to show that the frame is discarded and the output released.

// File: rtl/uw_pkg.sv
package uw_pkg;
   typedef enum logic [3:0] {
      K_NONE  = 4'd0,
      K_READ  = 4'd1,
      K_WRITE = 4'd2,
      K_CLEAR = 4'd3,
      K_WREN  = 4'd4,
      K_WRALL = 4'd5,
      K_WRDIS = 4'd6,
      K_PREAD = 4'd7,
      K_PEN   = 4'd8,
      K_PCLR  = 4'd9,
      K_PWR   = 4'd10,
      K_PDIS  = 4'd11
   } kind_e;

   typedef enum logic [2:0] {
      F_IDLE, F_OPC, F_ADR, F_DAT, F_RD, F_END
   } frame_e;
endpackage

// File: rtl/uw_in_sync.sv
module uw_in_sync #(
   parameter int N      = 4,
   parameter int STAGES = 0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] din,
   output logic [N-1:0] dout
);
   initial assert (STAGES >= 0 && STAGES <= 4) else $error("STAGES out of range");

   generate
      if (STAGES == 0) begin : g_pass
         assign dout = din;
      end else begin : g_chain
         logic [N-1:0] stg [STAGES];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 0; i < STAGES; i++) stg[i] <= '0;
            end else begin
               stg[0] <= din;
               for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
            end
         end
         assign dout = stg[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/uw_cmd_decode.sv
module uw_cmd_decode
   import uw_pkg::*;
#(
   parameter int AW = 8
) (
   input  logic          psel,
   input  logic [1:0]    opc,
   input  logic [AW-1:0] adr,
   output kind_e         kind,
   output logic          needs_data,
   output logic          is_read
);
   logic [1:0] top2;
   logic       ones, zeros;

   assign top2  = adr[AW-1 -: 2];
   assign ones  = &adr;
   assign zeros = ~|adr;

   always_comb begin
      kind = K_NONE;
      if (!psel) begin
         unique case (opc)
            2'b10: kind = K_READ;
            2'b01: kind = K_WRITE;
            2'b11: kind = K_CLEAR;
            default: begin
               unique case (top2)
                  2'b11:   kind = K_WREN;
                  2'b01:   kind = K_WRALL;
                  2'b00:   kind = K_WRDIS;
                  default: kind = K_NONE;
               endcase
            end
         endcase
      end else begin
         unique case (opc)
            2'b10: kind = K_PREAD;
            2'b01: kind = K_PWR;
            2'b11: kind = ones ? K_PCLR : K_NONE;
            default: begin
               if (top2 == 2'b11)  kind = K_PEN;
               else if (zeros)     kind = K_PDIS;
               else                kind = K_NONE;
            end
         endcase
      end
   end

   assign needs_data = (kind == K_WRITE) || (kind == K_WRALL);
   assign is_read    = (kind == K_READ)  || (kind == K_PREAD);
endmodule

// File: rtl/uw_rd_shift.sv
module uw_rd_shift #(
   parameter int AW = 8,
   parameter int DW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clear,
   input  logic          start,
   input  logic          start_prot,
   input  logic [AW-1:0] start_addr,
   input  logic          step,
   input  logic [DW-1:0] rd_data,
   input  logic [AW-1:0] prot_addr,
   output logic [AW-1:0] rd_addr,
   output logic          dout,
   output logic          dout_oe
);
   localparam int BW = (DW > 1) ? $clog2(DW) : 1;
   localparam logic [BW-1:0] LAST_ARR  = BW'(DW - 1);
   localparam logic [BW-1:0] LAST_PROT = BW'(AW - 1);

   logic          act, prot, fin;
   logic [BW-1:0] bcnt;
   logic [DW-1:0] sr, word;
   logic [AW-1:0] ptr;
   logic [BW-1:0] last;

   always_comb begin
      word = rd_data;
      if (prot) word = {prot_addr, {(DW-AW){1'b0}}};
   end
   assign last = prot ? LAST_PROT : LAST_ARR;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act <= 1'b0; prot <= 1'b0; fin <= 1'b0;
         bcnt <= '0; sr <= '0; ptr <= '0; dout <= 1'b0;
      end else if (clear) begin
         act <= 1'b0; fin <= 1'b0; bcnt <= '0; dout <= 1'b0;
      end else if (start) begin
         act  <= 1'b1;
         prot <= start_prot;
         fin  <= 1'b0;
         ptr  <= start_addr;
         bcnt <= '0;
         dout <= 1'b0;
      end else if (step && act) begin
         if (fin) begin
            act  <= 1'b0;
            dout <= 1'b0;
         end else if (bcnt == '0) begin
            dout <= word[DW-1];
            sr   <= word << 1;
            bcnt <= BW'(1);
         end else begin
            dout <= sr[DW-1];
            sr   <= sr << 1;
            if (bcnt == last) begin
               bcnt <= '0;
               if (prot) fin <= 1'b1;
               else      ptr <= ptr + 1'b1;
            end else begin
               bcnt <= bcnt + 1'b1;
            end
         end
      end
   end

   assign rd_addr = ptr;
   assign dout_oe = act;
endmodule

// File: rtl/uw_mem_slave.sv
module uw_mem_slave
   import uw_pkg::*;
#(
   parameter int AW          = 8,
   parameter int DW          = 16,
   parameter int SYNC_STAGES = 0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cs,
   input  logic          sck,
   input  logic          di,
   input  logic          psel,
   output logic [AW-1:0] rd_addr,
   input  logic [DW-1:0] rd_data,
   input  logic [AW-1:0] prot_addr,
   output logic          dout,
   output logic          dout_oe,
   output logic          cmd_valid,
   output logic [3:0]    cmd_kind,
   output logic [AW-1:0] cmd_addr,
   output logic [DW-1:0] cmd_data
);
   localparam int CW = $clog2((DW > AW ? DW : AW) + 1);
   localparam logic [CW-1:0] A_LAST = CW'(AW - 1);
   localparam logic [CW-1:0] D_LAST = CW'(DW - 1);

   initial assert (AW >= 2)  else $error("AW must be at least 2");
   initial assert (DW >= 2)  else $error("DW must be at least 2");
   initial assert (DW >= AW) else $error("DW must cover AW");

   logic cs_s, sck_s, di_s, psel_s, sck_q, rise;

   uw_in_sync #(.N(4), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n),
      .din({cs, sck, di, psel}),
      .dout({cs_s, sck_s, di_s, psel_s})
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sck_q <= 1'b0;
      else        sck_q <= sck_s;
   end
   assign rise = cs_s & sck_s & ~sck_q;

   frame_e        st;
   logic [CW-1:0] cnt;
   logic [1:0]    opc;
   logic [AW-1:0] adr, adr_n;
   logic [DW-1:0] dat, dat_n;
   kind_e         kind_n, pend;
   logic          need_d, is_rd, adr_done, rd_start;

   assign adr_n = {adr[AW-2:0], di_s};
   assign dat_n = {dat[DW-2:0], di_s};

   uw_cmd_decode #(.AW(AW)) u_dec (
      .psel(psel_s), .opc(opc), .adr(adr_n),
      .kind(kind_n), .needs_data(need_d), .is_read(is_rd)
   );

   assign adr_done = rise && (st == F_ADR) && (cnt == A_LAST);
   assign rd_start = adr_done && is_rd;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st <= F_IDLE; cnt <= '0; opc <= '0; adr <= '0; dat <= '0;
         pend <= K_NONE; cmd_valid <= 1'b0; cmd_kind <= '0;
         cmd_addr <= '0; cmd_data <= '0;
      end else if (!cs_s) begin
         st <= F_IDLE; cnt <= '0; cmd_valid <= 1'b0;
      end else begin
         cmd_valid <= 1'b0;
         if (rise) begin
            unique case (st)
               F_IDLE: if (di_s) begin st <= F_OPC; cnt <= '0; end
               F_OPC: begin
                  opc <= {opc[0], di_s};
                  if (cnt == CW'(1)) begin st <= F_ADR; cnt <= '0; end
                  else cnt <= cnt + 1'b1;
               end
               F_ADR: begin
                  adr <= adr_n;
                  if (cnt == A_LAST) begin
                     cnt  <= '0;
                     pend <= kind_n;
                     if (kind_n == K_NONE) st <= F_END;
                     else if (need_d)     st <= F_DAT;
                     else begin
                        cmd_valid <= 1'b1;
                        cmd_kind  <= kind_n;
                        cmd_addr  <= adr_n;
                        st        <= is_rd ? F_RD : F_END;
                     end
                  end else cnt <= cnt + 1'b1;
               end
               F_DAT: begin
                  dat <= dat_n;
                  if (cnt == D_LAST) begin
                     cmd_valid <= 1'b1;
                     cmd_kind  <= pend;
                     cmd_addr  <= adr;
                     cmd_data  <= dat_n;
                     st        <= F_END;
                  end else cnt <= cnt + 1'b1;
               end
               default: ;
            endcase
         end
      end
   end

   uw_rd_shift #(.AW(AW), .DW(DW)) u_rd (
      .clk(clk), .rst_n(rst_n),
      .clear(!cs_s),
      .start(rd_start),
      .start_prot(kind_n == K_PREAD),
      .start_addr(adr_n),
      .step(rise),
      .rd_data(rd_data),
      .prot_addr(prot_addr),
      .rd_addr(rd_addr),
      .dout(dout),
      .dout_oe(dout_oe)
   );
endmodule

// File: rtl/uw_mem_slave_chk.sv
module uw_mem_slave_chk #(
   parameter int AW = 8
) (
   input logic          clk,
   input logic          rst_n,
   input logic          cs_s,
   input logic          sck_s,
   input logic          dout,
   input logic          dout_oe,
   input logic          cmd_valid,
   input logic [3:0]    cmd_kind,
   input logic [AW-1:0] cmd_addr
);
   logic sck_p;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sck_p <= 1'b0;
      else        sck_p <= sck_s;
   end

   AST_OE_DROPS_ON_DESELECT: assert property (@(posedge clk) disable iff (!rst_n)
      !cs_s |=> !dout_oe); // R8
   AST_CMD_NEEDS_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid |-> $past(cs_s)); // R8
   AST_CMD_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid |=> !cmd_valid); // R9
   AST_CMD_KIND_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid |-> (cmd_kind != 4'd0 && cmd_kind <= 4'd11)); // R3
   AST_PCLR_ALL_ONES: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_kind == 4'd9) |-> (&cmd_addr)); // R4
   AST_DUMMY_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(dout_oe) |-> !dout); // R5
   AST_OUT_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
      (dout_oe && $past(dout_oe) && dout != $past(dout))
      |-> $past(sck_s && !sck_p)); // R5
endmodule

bind uw_mem_slave uw_mem_slave_chk #(.AW(AW)) u_chk (
   .clk(clk), .rst_n(rst_n), .cs_s(cs_s), .sck_s(sck_s),
   .dout(dout), .dout_oe(dout_oe), .cmd_valid(cmd_valid),
   .cmd_kind(cmd_kind), .cmd_addr(cmd_addr)
);

// File: tb/tb_uw_mem_slave.sv
`timescale 1ns/1ps
module tb_uw_mem_slave;
   localparam int AW = 8;
   localparam int DW = 16;

   logic clk = 1'b0, rst_n = 1'b0;
   logic cs = 1'b0, sck = 1'b0, di = 1'b0, psel = 1'b0;
   logic [AW-1:0] rd_addr, prot_addr;
   logic [DW-1:0] rd_data, cmd_data;
   logic dout, dout_oe, cmd_valid;
   logic [3:0] cmd_kind;
   logic [AW-1:0] cmd_addr;

   int pass_n = 0, fail_n = 0, cycles = 0;
   bit done = 0;

   always #4 clk = ~clk;

   function automatic logic [DW-1:0] mem_word(input logic [AW-1:0] a);
      return {a ^ 8'hA5, ~a};
   endfunction
   assign rd_data = mem_word(rd_addr);

   uw_mem_slave #(.AW(AW), .DW(DW)) dut (
      .clk(clk), .rst_n(rst_n), .cs(cs), .sck(sck), .di(di), .psel(psel),
      .rd_addr(rd_addr), .rd_data(rd_data), .prot_addr(prot_addr),
      .dout(dout), .dout_oe(dout_oe), .cmd_valid(cmd_valid),
      .cmd_kind(cmd_kind), .cmd_addr(cmd_addr), .cmd_data(cmd_data)
   );

   task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
      if (act === exp) pass_n++;
      else begin
         fail_n++;
         $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
      end
   endtask

   function automatic int ref_kind(input logic ps, input logic [1:0] op, input logic [7:0] a);
      if (!ps) begin
         if (op == 2'b10) return 1;
         if (op == 2'b01) return 2;
         if (op == 2'b11) return 3;
         if (a[7:6] == 2'b11) return 4;
         if (a[7:6] == 2'b01) return 5;
         if (a[7:6] == 2'b00) return 6;
         return 0;
      end
      if (op == 2'b10) return 7;
      if (op == 2'b01) return 10;
      if (op == 2'b11) return (a == 8'hFF) ? 9 : 0;
      if (a[7:6] == 2'b11) return 8;
      if (a == 8'h00) return 11;
      return 0;
   endfunction

   // One serial clock period; checks the outputs in every system clock of it.
   task automatic pulse(input logic d, input logic e_oe, input logic e_do,
                        input logic e_cv, input int e_kind, input logic [7:0] e_addr,
                        input logic e_hasd, input logic [15:0] e_data, input string r);
      di = d; sck = 1'b1;
      @(negedge clk);
      chk({r, " oe"}, dout_oe, e_oe);
      if (e_oe) chk({r, " dout"}, dout, e_do);
      chk({r, " R9 valid"}, cmd_valid, e_cv);
      if (e_cv) begin
         chk({r, " kind"}, cmd_kind, e_kind);
         chk({r, " R9 addr"}, cmd_addr, e_addr);
         if (e_hasd) chk({r, " R9 data"}, cmd_data, e_data);
      end
      sck = 1'b0;
      @(negedge clk);
      chk({r, " R9 pulse end"}, cmd_valid, 0);
      @(negedge clk);
   endtask

   task automatic deselect(input string r);
      cs = 1'b0;
      @(negedge clk);
      @(negedge clk);
      chk({r, " R8 oe after deselect"}, dout_oe, 0);
      cs = 1'b1;
      @(negedge clk);
   endtask

   // Sends a frame; a read frame leaves the stream open.
   task automatic send(input logic ps, input int lead, input logic [1:0] op,
                       input logic [7:0] a, input logic [15:0] d, input string r);
      int k;
      bit nd, rd;
      k  = ref_kind(ps, op, a);
      nd = (k == 2 || k == 5);
      rd = (k == 1 || k == 7);
      psel = ps;
      for (int i = 0; i < lead; i++) pulse(0, 0, 0, 0, 0, 0, 0, 0, {r, " R2 lead"});
      pulse(1, 0, 0, 0, 0, 0, 0, 0, {r, " R2 start"});
      pulse(op[1], 0, 0, 0, 0, 0, 0, 0, {r, " R10 op"});
      pulse(op[0], 0, 0, 0, 0, 0, 0, 0, {r, " R10 op"});
      for (int i = AW - 1; i > 0; i--) pulse(a[i], 0, 0, 0, 0, 0, 0, 0, {r, " R10 addr"});
      pulse(a[0], rd, 0, (k != 0) && !nd, k, a, 0, 0, {r, " R5 last addr"});
      if (nd) begin
         for (int i = DW - 1; i > 0; i--) pulse(d[i], 0, 0, 0, 0, 0, 0, 0, {r, " R10 data"});
         pulse(d[0], 0, 0, 1, k, a, 1, d, {r, " last data"});
      end
   endtask

   task automatic stream(input logic [7:0] a0, input int nbits, input string r);
      logic q[$];
      logic [7:0] a;
      logic [15:0] w;
      a = a0;
      while (q.size() < nbits) begin
         w = mem_word(a);
         for (int b = DW - 1; b >= 0; b--) q.push_back(w[b]);
         a = a + 8'd1;
      end
      for (int i = 0; i < nbits; i++) pulse(0, 1, q.pop_front(), 0, 0, 0, 0, 0, r);
   endtask

   task automatic finish_run();
      done = 1;
      $display("%0d/%0d checks passed", pass_n, pass_n + fail_n);
      $finish;
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 150000 && !done) begin
         fail_n++;
         $display("FAIL watchdog actual=%0d expected=<150000", cycles);
         finish_run();
      end
   end

   initial begin
      prot_addr = 8'h5B;
      repeat (3) @(negedge clk);
      chk("R1 oe in reset", dout_oe, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 oe after reset", dout_oe, 0);
      chk("R1 valid after reset", cmd_valid, 0);
      cs = 1'b1;
      @(negedge clk);

      // R2 R3 array-side decode
      send(0, 3, 2'b00, 8'hC5, 0, "R2 R3 wren");            deselect("wren");
      send(0, 0, 2'b01, 8'h3C, 16'hBEEF, "R3 write");       deselect("write");
      send(0, 1, 2'b11, 8'h12, 0, "R3 clear");              deselect("clear");
      send(0, 0, 2'b00, 8'h40, 16'h1234, "R3 wrall");       deselect("wrall");
      send(0, 0, 2'b00, 8'h2A, 0, "R3 wrdis");              deselect("wrdis");
      send(0, 0, 2'b00, 8'h80, 0, "R3 reserved");           deselect("reserved");

      // R5 R6 reads across a word boundary and across the wrap
      send(0, 0, 2'b10, 8'h10, 0, "R5 read");
      stream(8'h10, 2 * DW + 3, "R6 seq read");
      deselect("read");
      send(0, 2, 2'b10, 8'hFF, 0, "R6 read top");
      stream(8'hFF, 2 * DW, "R6 wrap read");
      deselect("wrap");

      // R4 R7 protect side
      send(1, 0, 2'b10, 8'h33, 0, "R7 pread");
      stream(8'h00, 0, "R7");
      for (int i = AW - 1; i >= 0; i--) pulse(0, 1, prot_addr[i], 0, 0, 0, 0, 0, "R7 pbits");
      pulse(0, 0, 0, 0, 0, 0, 0, 0, "R7 release");
      deselect("pread");
      send(1, 0, 2'b00, 8'hC0, 0, "R4 pen");                deselect("pen");
      send(1, 0, 2'b11, 8'hFF, 0, "R4 pclr");               deselect("pclr");
      send(1, 0, 2'b11, 8'hFE, 0, "R4 pclr reserved");      deselect("pclr_r");
      send(1, 0, 2'b01, 8'h40, 0, "R4 pwr");                deselect("pwr");
      send(1, 0, 2'b00, 8'h00, 0, "R4 pdis");               deselect("pdis");
      send(1, 0, 2'b00, 8'h01, 0, "R4 reserved");           deselect("p_r");

      // R8 abort inside a frame, then a clean frame
      psel = 0;
      pulse(1, 0, 0, 0, 0, 0, 0, 0, "R8 abort start");
      pulse(0, 0, 0, 0, 0, 0, 0, 0, "R8 abort op");
      pulse(1, 0, 0, 0, 0, 0, 0, 0, "R8 abort op");
      for (int i = 0; i < 4; i++) pulse(1, 0, 0, 0, 0, 0, 0, 0, "R8 abort addr");
      deselect("R8 mid frame");
      send(0, 0, 2'b10, 8'h20, 0, "R8 restart read");
      stream(8'h20, 5, "R8 restart stream");
      deselect("R8 mid stream");
      pulse(0, 0, 0, 0, 0, 0, 0, 0, "R8 idle after abort");

      finish_run();
   end
endmodule